// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Engine

This block is the device side of a small nonvolatile memory with a three-wire serial interface. A host selects the device with a chip-select line, clocks it with a slow serial clock and sends instructions on a data-in line. The device answers on a data-out line that it drives only when it has something to say. A strap input sets the layout. In the wide layout there are 64 words of 16 bits. In the narrow layout the same storage is seen as 128 bytes. The storage is a register array in the block. The self-timed program or erase period is a fixed number of system clock cycles, set by the `TEW_CYCLES` parameter.

The chip select, serial clock and data-in inputs are first synchronised into the system clock. Their edges are then detected. Serial edges are therefore seen a few system cycles late, so the serial clock must be much slower than the system clock.

There are seven instructions: read, write, erase one, erase all, write all, write enable and write disable. A write-enable latch guards every instruction that changes the array. After a modifying instruction has launched, the host can poll data-out to see whether the device is still busy.

Top module: `mwEeprom`

## Requirements
- R1: Inputs are sampled on rising serial-clock edges while chip select is high. A frame is a 1 start bit, then a 2-bit opcode, then an address. The address is 6 bits when `orgWide`=1 and 7 bits when `orgWide`=0, and all fields are sent MSB first. Zeros received before the start bit are ignored.
- R2: Opcode 10 is a read. On the edge that carries the last address bit, data-out is enabled and drives a single 0. Each later rising edge presents the next data bit, MSB first: 16 bits in the wide layout or 8 bits in the narrow layout. Data-out is released to high impedance whenever chip select is low.
- R3: Opcode 01 is a write. It is followed by a data field of 16 bits (wide) or 8 bits (narrow). The store starts on the falling edge of chip select and overwrites the old contents without a prior erase.
- R4: Opcode 11 erases one location to all ones. Opcode 00 with top address bits 10 erases every location to all ones.
- R5: Opcode 00 with top address bits 01 is a write-all. It takes a data field like a write and stores that data in every word. In the narrow layout the byte is stored in both halves of every word.
- R6: Opcode 00 with top address bits 11 sets the write-enable latch, and top address bits 00 clear it. While the latch is clear, write, erase, erase-all and write-all change nothing and start no busy period. Reads work in either state of the latch.
- R7: After a modifying instruction has launched, data-out is driven while chip select is high. It reads 0 for `TEW_CYCLES` system cycles and then 1. A 1 clocked in on data-in releases data-out to high impedance only in the ready state. The indication stays pending until it is released in this way.
- R8: Instructions clocked in while the device is busy are ignored.
- R9: If chip select falls before a frame is complete, nothing is stored, no busy period starts and the next instruction is decoded normally.
- R10: In the narrow layout, byte address bits [6:1] select the word. Bit 0 = 1 selects bits [15:8] and bit 0 = 0 selects bits [7:0].
- R11: After reset, data-out is not enabled, the write-enable latch is clear and every word reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset, models power-up |
| csIn | input | 1 | Chip select, active high |
| skIn | input | 1 | Serial clock from the host |
| diIn | input | 1 | Serial data in |
| orgWide | input | 1 | Layout strap: 1 selects 16-bit words, 0 selects bytes |
| doOut | output | 1 | Serial data out value |
| doOe | output | 1 | Output enable for data-out (0 = high impedance) |

## Verification
The assertions are checked on every cycle. They check that no array-changing strobe appears while the write-enable latch is clear, and that at most one operation strobe is active at a time. They also check that a wide write or an erase-all is visible in the array one cycle after its strobe, that a read always begins with the dummy bit, that the busy counter stays within its window, and that no read is started from the busy state. Only the bench scenarios can show the end-to-end serial behaviour. That covers the frame lengths in both layouts and the bit order of read data, the mapping of byte addresses onto words, and the busy-then-ready indication and its release. It also covers aborted and locked instructions leaving the array untouched, and frames sent during a busy period being dropped.

// File: rtl/mwe_pkg.sv
package mwe_pkg;
  parameter int BYTE_W  = 8;
  parameter int WORD_W  = 2 * BYTE_W;
  parameter int WADDR_W = 6;
  parameter int NUM_WORDS = 1 << WADDR_W;
  parameter int BADDR_W = WADDR_W + 1;
  parameter int CMD_W   = 2 + BADDR_W;
  parameter int CNT_W   = $clog2(WORD_W + 1);

  typedef enum logic [2:0] {
    OP_NONE, OP_WRITE, OP_ERASE, OP_ERAL, OP_WRAL
  } op_t;

  typedef struct packed {
    logic               rdLoad;
    logic               rdShift;
    logic               progOne;
    logic               eraseOne;
    logic               eraseAll;
    logic               progAll;
    logic               wide;
    logic               wel;
    logic [BADDR_W-1:0] addr;
    logic [WORD_W-1:0]  data;
  } mwe_strobe_t;
endpackage

// File: rtl/mwe_ctrl.sv
module mwe_ctrl
  import mwe_pkg::*;
#(
  parameter int TEW_CYCLES  = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csIn,
  input  logic        skIn,
  input  logic        diIn,
  input  logic        orgWide,
  input  logic        rdBit,
  output mwe_strobe_t stb,
  output logic        doOut,
  output logic        doOe
);
  localparam int BUSY_W = $clog2(TEW_CYCLES + 1);
  localparam int CMD_WIDE = 2 + WADDR_W;

  typedef enum logic [2:0] {
    ST_HUNT, ST_CMD, ST_DATA, ST_READ, ST_ARMED, ST_BUSY, ST_READY
  } state_t;

  logic [2:0] syncPipe [SYNC_STAGES];
  logic csS, skS, diS, skPrev, csPrev, skRise, csFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncPipe[i] <= '0;
    end else begin
      syncPipe[0] <= {csIn, skIn, diIn};
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
    end
  end

  assign csS = syncPipe[SYNC_STAGES-1][2];
  assign skS = syncPipe[SYNC_STAGES-1][1];
  assign diS = syncPipe[SYNC_STAGES-1][0];
  assign skRise = skS & ~skPrev;
  assign csFall = ~csS & csPrev;

  state_t             state;
  logic [CNT_W-1:0]   bitCnt;
  logic [CMD_W-1:0]   cmdSh;
  logic [WORD_W-1:0]  dataSh;
  logic [BADDR_W-1:0] addrLat;
  logic               wideLat;
  logic               wel;
  logic               dummy;
  op_t                pendOp;
  op_t                launchOp;
  logic               pRdLoad;
  logic               pRdShift;
  logic [BUSY_W-1:0]  busyCnt;

  // frame decode including the bit arriving on this edge
  logic [CMD_W-1:0]   frameNext;
  logic [1:0]         opDec;
  logic [1:0]         subDec;
  logic [BADDR_W-1:0] addrDec;
  logic [CNT_W-1:0]   cmdLast;
  logic [CNT_W-1:0]   dataLast;

  always_comb begin
    frameNext = {cmdSh[CMD_W-2:0], diS};
    if (wideLat) begin
      opDec   = frameNext[WADDR_W+1 -: 2];
      addrDec = {1'b0, frameNext[WADDR_W-1:0]};
      subDec  = frameNext[WADDR_W-1 -: 2];
    end else begin
      opDec   = frameNext[WADDR_W+2 -: 2];
      addrDec = frameNext[WADDR_W:0];
      subDec  = frameNext[WADDR_W -: 2];
    end
    cmdLast  = wideLat ? CNT_W'(CMD_WIDE - 1) : CNT_W'(CMD_WIDE);
    dataLast = wideLat ? CNT_W'(WORD_W - 1) : CNT_W'(BYTE_W - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      skPrev   <= 1'b0;
      csPrev   <= 1'b0;
      state    <= ST_HUNT;
      bitCnt   <= '0;
      cmdSh    <= '0;
      dataSh   <= '0;
      addrLat  <= '0;
      wideLat  <= 1'b1;
      wel      <= 1'b0;
      dummy    <= 1'b0;
      pendOp   <= OP_NONE;
      launchOp <= OP_NONE;
      pRdLoad  <= 1'b0;
      pRdShift <= 1'b0;
      busyCnt  <= '0;
    end else begin
      skPrev   <= skS;
      csPrev   <= csS;
      launchOp <= OP_NONE;
      pRdLoad  <= 1'b0;
      pRdShift <= 1'b0;
      unique case (state)
        ST_HUNT: begin
          if (skRise && csS && diS) begin
            state   <= ST_CMD;
            bitCnt  <= '0;
            cmdSh   <= '0;
            wideLat <= orgWide;
          end
        end
        ST_CMD: begin
          if (csFall) begin
            state <= ST_HUNT;
          end else if (skRise && csS) begin
            cmdSh  <= frameNext;
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == cmdLast) begin
              addrLat <= addrDec;
              bitCnt  <= '0;
              dataSh  <= '0;
              unique case (opDec)
                2'b10: begin
                  state   <= ST_READ;
                  dummy   <= 1'b1;
                  pRdLoad <= 1'b1;
                end
                2'b01: begin
                  state  <= ST_DATA;
                  pendOp <= OP_WRITE;
                end
                2'b11: begin
                  state  <= ST_ARMED;
                  pendOp <= OP_ERASE;
                end
                default: begin
                  unique case (subDec)
                    2'b11: begin wel <= 1'b1; pendOp <= OP_NONE; state <= ST_ARMED; end
                    2'b00: begin wel <= 1'b0; pendOp <= OP_NONE; state <= ST_ARMED; end
                    2'b10: begin pendOp <= OP_ERAL; state <= ST_ARMED; end
                    default: begin pendOp <= OP_WRAL; state <= ST_DATA; end
                  endcase
                end
              endcase
            end
          end
        end
        ST_DATA: begin
          if (csFall) begin
            state <= ST_HUNT;
          end else if (skRise && csS) begin
            dataSh <= {dataSh[WORD_W-2:0], diS};
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == dataLast) state <= ST_ARMED;
          end
        end
        ST_READ: begin
          if (csFall) begin
            state <= ST_HUNT;
            dummy <= 1'b0;
          end else if (skRise && csS) begin
            if (dummy) dummy <= 1'b0;
            else pRdShift <= 1'b1;
          end
        end
        ST_ARMED: begin
          if (csFall) begin
            if (pendOp != OP_NONE && wel) begin
              launchOp <= pendOp;
              busyCnt  <= '0;
              state    <= ST_BUSY;
            end else begin
              state <= ST_HUNT;
            end
          end
        end
        ST_BUSY: begin
          busyCnt <= busyCnt + 1'b1;
          if (busyCnt == BUSY_W'(TEW_CYCLES - 1)) state <= ST_READY;
        end
        ST_READY: begin
          if (skRise && csS && diS) state <= ST_HUNT;
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  always_comb begin
    stb.rdLoad   = pRdLoad;
    stb.rdShift  = pRdShift;
    stb.progOne  = (launchOp == OP_WRITE);
    stb.eraseOne = (launchOp == OP_ERASE);
    stb.eraseAll = (launchOp == OP_ERAL);
    stb.progAll  = (launchOp == OP_WRAL);
    stb.wide     = wideLat;
    stb.wel      = wel;
    stb.addr     = addrLat;
    stb.data     = dataSh;
  end

  assign doOe  = csS && (state == ST_READ || state == ST_BUSY || state == ST_READY);
  assign doOut = (state == ST_READ) ? (!dummy && rdBit) : (state == ST_READY);

  // R7: the busy window never runs past its programmed length
  assert_busy_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY) |-> (busyCnt < BUSY_W'(TEW_CYCLES)));

  // R8: nothing decoded during a busy period can start a read
  assert_busy_no_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY) |=> !pRdLoad);

  // R2: every read starts with the dummy zero
  assert_read_dummy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pRdLoad) |-> (state == ST_READ && dummy));

  // R3: a launched operation always enters the busy period
  assert_launch_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (launchOp != OP_NONE) |-> (state == ST_BUSY && busyCnt == '0));
endmodule

// File: rtl/mwe_datapath.sv
module mwe_datapath
  import mwe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  mwe_strobe_t stb,
  output logic        rdBit
);
  logic [WORD_W-1:0]  mem [NUM_WORDS];
  logic [WADDR_W-1:0] wordIdx;
  logic               laneHi;
  logic               laneLo;
  logic [WORD_W-1:0]  allData;

  assign wordIdx = stb.wide ? stb.addr[WADDR_W-1:0] : stb.addr[WADDR_W:1];
  assign laneHi  = stb.wide | stb.addr[0];
  assign laneLo  = stb.wide | ~stb.addr[0];
  assign allData = stb.wide ? stb.data : {2{stb.data[BYTE_W-1:0]}};

  for (genvar w = 0; w < NUM_WORDS; w++) begin : gWord
    logic hit;
    assign hit = (wordIdx == WADDR_W'(w));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mem[w] <= '1;
      end else if (stb.eraseAll) begin
        mem[w] <= '1;
      end else if (stb.progAll) begin
        mem[w] <= allData;
      end else if (stb.eraseOne && hit) begin
        if (laneHi) mem[w][WORD_W-1:BYTE_W] <= '1;
        if (laneLo) mem[w][BYTE_W-1:0] <= '1;
      end else if (stb.progOne && hit) begin
        if (stb.wide) mem[w] <= stb.data;
        else if (laneHi) mem[w][WORD_W-1:BYTE_W] <= stb.data[BYTE_W-1:0];
        else mem[w][BYTE_W-1:0] <= stb.data[BYTE_W-1:0];
      end
    end
  end

  logic [WORD_W-1:0] rdSh;
  logic [WORD_W-1:0] rdWord;
  logic [BYTE_W-1:0] rdByte;

  assign rdWord = mem[wordIdx];
  assign rdByte = stb.addr[0] ? rdWord[WORD_W-1:BYTE_W] : rdWord[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdSh <= '0;
    end else if (stb.rdLoad) begin
      rdSh <= stb.wide ? rdWord : {rdByte, {BYTE_W{1'b0}}};
    end else if (stb.rdShift) begin
      rdSh <= {rdSh[WORD_W-2:0], 1'b0};
    end
  end

  assign rdBit = rdSh[WORD_W-1];

  // R6: array-changing strobes only while the latch is set
  assert_locked_no_prog_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.progOne || stb.eraseOne || stb.eraseAll || stb.progAll) |-> stb.wel);

  // R3: operation strobes never overlap
  assert_one_op_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.rdLoad, stb.progOne, stb.eraseOne, stb.eraseAll, stb.progAll}));

  // R3: a wide write lands in the addressed word
  assert_word_written_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.progOne && stb.wide) |=> (mem[$past(wordIdx)] == $past(stb.data)));

  // R4: erase-all leaves the end words all ones
  assert_erase_all_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.eraseAll |=> (mem[0] == '1 && mem[NUM_WORDS-1] == '1));
endmodule

// File: rtl/mwEeprom.sv
module mwEeprom
  import mwe_pkg::*;
#(
  parameter int TEW_CYCLES  = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  input  logic orgWide,
  output logic doOut,
  output logic doOe
);
  mwe_strobe_t stb;
  logic        rdBit;

  mwe_ctrl #(.TEW_CYCLES(TEW_CYCLES), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .csIn(csIn), .skIn(skIn), .diIn(diIn),
    .orgWide(orgWide), .rdBit(rdBit), .stb(stb), .doOut(doOut), .doOe(doOe)
  );

  mwe_datapath uData (
    .clk(clk), .rstN(rstN), .stb(stb), .rdBit(rdBit)
  );
endmodule

// File: tb/mwEeprom_test.sv
module mwEeprom_test;
  localparam int HALF = 6;
  localparam int TEW  = 400;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, csIn, skIn, diIn, orgWide;
  logic doOut, doOe;
  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [15:0] model [64];

  mwEeprom #(.TEW_CYCLES(TEW)) uut (
    .clk(clk), .rstN(rstN), .csIn(csIn), .skIn(skIn), .diIn(diIn),
    .orgWide(orgWide), .doOut(doOut), .doOe(doOe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clockBit(input logic b, output logic o, output logic oe);
    diIn = b;
    waitClk(HALF);
    o = doOut;
    oe = doOe;
    skIn = 1'b1;
    waitClk(HALF);
    skIn = 1'b0;
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    logic o, oe;
    for (int i = n - 1; i >= 0; i--) clockBit(v[i], o, oe);
  endtask

  task automatic csOn();
    csIn = 1'b1;
    waitClk(HALF);
  endtask

  task automatic csOff();
    csIn = 1'b0;
    waitClk(HALF);
  endtask

  task automatic sendCmd(input logic wide, input logic [1:0] op, input logic [6:0] addr);
    sendBits(32'd1, 1);
    sendBits({30'd0, op}, 2);
    sendBits({25'd0, addr}, wide ? 6 : 7);
  endtask

  task automatic launch(input logic wide, input logic [1:0] op, input logic [6:0] addr,
                        input logic [15:0] data, input bit hasData);
    orgWide = wide;
    csOn();
    sendCmd(wide, op, addr);
    if (hasData) sendBits({16'd0, data}, wide ? 16 : 8);
    csOff();
  endtask

  task automatic waitReady(input string req);
    logic o, oe;
    int n = 0;
    csOn();
    while (!(doOe && doOut) && n < TEW + 100) begin
      waitClk(1);
      n++;
    end
    check(doOe && doOut, req, {30'd0, doOe, doOut}, 32'h3);
    clockBit(1'b1, o, oe);
    check(!doOe, {req, " release"}, {31'd0, doOe}, 32'h0);
    csOff();
  endtask

  task automatic readVal(input logic wide, input logic [6:0] addr, input int zeros,
                         output logic [15:0] val, output bit dummyOk);
    logic o, oe;
    int n;
    orgWide = wide;
    csOn();
    if (zeros > 0) sendBits(32'd0, zeros);
    sendCmd(wide, 2'b10, addr);
    n = wide ? 16 : 8;
    clockBit(1'b0, o, oe);
    dummyOk = oe && (o == 1'b0);
    val = '0;
    for (int i = 0; i < n; i++) begin
      clockBit(1'b0, o, oe);
      val = {val[14:0], o};
    end
    csOff();
  endtask

  function automatic logic [15:0] expRead(input logic wide, input logic [6:0] a);
    if (wide) return model[a[5:0]];
    return a[0] ? {8'h00, model[a[6:1]][15:8]} : {8'h00, model[a[6:1]][7:0]};
  endfunction

  task automatic checkRead(input logic wide, input logic [6:0] addr, input string req);
    logic [15:0] v;
    bit d;
    readVal(wide, addr, 0, v, d);
    check(d, {req, " dummy"}, {31'd0, d}, 32'h1);
    check(v == expRead(wide, addr), req, {16'd0, v}, {16'd0, expRead(wide, addr)});
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 16'h0B3D) ^ 16'hC35A);
  endfunction

  initial begin
    waitClk(195000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    bit d;
    logic o, oe;
    rstN = 1'b0; csIn = 1'b0; skIn = 1'b0; diIn = 1'b0; orgWide = 1'b1;
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);

    // R11: reset state
    check(!doOe, "R11 oe after reset", {31'd0, doOe}, 32'h0);
    checkRead(1'b1, 7'd0, "R11 erased word 0");
    checkRead(1'b1, 7'd63, "R11 erased word 63");

    // R1: leading zeros before the start bit
    readVal(1'b1, 7'd5, 3, v, d);
    check(v == 16'hFFFF && d, "R1 leading zeros", {16'd0, v}, 32'hFFFF);

    // R6: locked write is ignored and starts no busy period
    launch(1'b1, 2'b01, 7'd3, 16'h1234, 1);
    csOn();
    check(!doOe, "R6 locked write no busy", {31'd0, doOe}, 32'h0);
    csOff();
    checkRead(1'b1, 7'd3, "R6 locked write unchanged");

    // R6: write enable
    launch(1'b1, 2'b00, {1'b0, 2'b11, 4'b0}, 16'h0, 0);

    // R7: busy then ready, release refused while busy
    launch(1'b1, 2'b01, 7'd0, pat(0), 1);
    model[0] = pat(0);
    csOn();
    waitClk(4);
    check(doOe && !doOut, "R7 busy low", {30'd0, doOe, doOut}, 32'h2);
    clockBit(1'b1, o, oe);
    check(doOe && !doOut, "R7 release refused while busy", {30'd0, doOe, doOut}, 32'h2);
    csOff();
    waitReady("R7 ready high");

    // R3: write every word
    for (int a = 1; a < 64; a++) begin
      launch(1'b1, 2'b01, 7'(a), pat(a), 1);
      model[a] = pat(a);
      waitReady("R3 write ready");
    end
    for (int a = 0; a < 64; a++) checkRead(1'b1, 7'(a), "R3 R2 word readback");

    // R10: byte view of the same array
    for (int a = 0; a < 128; a++) checkRead(1'b0, 7'(a), "R10 byte readback");

    // R10: byte writes land in the selected half
    launch(1'b0, 2'b01, 7'd5, 16'h003C, 1);
    model[2][15:8] = 8'h3C;
    waitReady("R10 byte write ready");
    launch(1'b0, 2'b01, 7'd8, 16'h00C7, 1);
    model[4][7:0] = 8'hC7;
    waitReady("R10 byte write ready");
    checkRead(1'b1, 7'd2, "R10 upper byte write");
    checkRead(1'b1, 7'd4, "R10 lower byte write");

    // R3: overwrite without erase
    launch(1'b1, 2'b01, 7'd2, 16'h0F0F, 1);
    model[2] = 16'h0F0F;
    waitReady("R3 overwrite ready");
    checkRead(1'b1, 7'd2, "R3 overwrite");

    // R4: erase one word
    launch(1'b1, 2'b11, 7'd7, 16'h0, 0);
    model[7] = 16'hFFFF;
    waitReady("R4 erase ready");
    checkRead(1'b1, 7'd6, "R4 neighbour below");
    checkRead(1'b1, 7'd7, "R4 erased word");
    checkRead(1'b1, 7'd8, "R4 neighbour above");

    // R8: frame sent while busy is ignored
    launch(1'b1, 2'b01, 7'd9, 16'hA55A, 1);
    model[9] = 16'hA55A;
    csOn();
    sendCmd(1'b1, 2'b11, 7'd10);
    csOff();
    waitReady("R8 ready after busy");
    checkRead(1'b1, 7'd9, "R8 write before busy frame");
    checkRead(1'b1, 7'd10, "R8 erase during busy ignored");

    // R9: aborted write frame
    orgWide = 1'b1;
    csOn();
    sendCmd(1'b1, 2'b01, 7'd11);
    sendBits(32'h15, 5);
    csOff();
    csOn();
    check(!doOe, "R9 abort no busy", {31'd0, doOe}, 32'h0);
    csOff();
    checkRead(1'b1, 7'd11, "R9 aborted write unchanged");

    // R4: erase all
    launch(1'b1, 2'b00, {1'b0, 2'b10, 4'b0}, 16'h0, 0);
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    waitReady("R4 erase all ready");
    for (int a = 0; a < 64; a += 5) checkRead(1'b1, 7'(a), "R4 erase all");

    // R5: write all, wide then narrow
    launch(1'b1, 2'b00, {1'b0, 2'b01, 4'b0}, 16'h1234, 1);
    for (int i = 0; i < 64; i++) model[i] = 16'h1234;
    waitReady("R5 write all ready");
    for (int a = 0; a < 64; a += 5) checkRead(1'b1, 7'(a), "R5 write all wide");
    launch(1'b0, 2'b00, {2'b01, 5'b0}, 16'h00A5, 1);
    for (int i = 0; i < 64; i++) model[i] = 16'hA5A5;
    waitReady("R5 write all narrow ready");
    for (int a = 0; a < 64; a += 5) checkRead(1'b1, 7'(a), "R5 R10 write all narrow");

    // R6: write disable blocks writes and erase-all, reads still work
    launch(1'b1, 2'b00, {1'b0, 2'b00, 4'b0}, 16'h0, 0);
    launch(1'b1, 2'b01, 7'd3, 16'h7777, 1);
    csOn();
    check(!doOe, "R6 disabled write no busy", {31'd0, doOe}, 32'h0);
    csOff();
    launch(1'b1, 2'b00, {1'b0, 2'b10, 4'b0}, 16'h0, 0);
    checkRead(1'b1, 7'd3, "R6 disabled write unchanged");
    checkRead(1'b1, 7'd40, "R6 disabled erase all unchanged");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule